// File: doc/BRIEF.md
# Spill-Gated Trigger State Scaler Bank

This block holds the event scalers of a trigger unit. During a beam spill it counts trigger strobes and, for each nonzero trigger lookup state code, how often that code came with a trigger. Every counted quantity has two 32-bit counters. The "all" counter sees every trigger, including those lost to dead time. The "read-out" counter sees only triggers flagged as accepted. Subtracting one from the other gives the dead-time losses.

The spill input is asynchronous. It passes through a synchroniser, and the synchronised level gates all counting. When the synchronised spill rises, every counter in the bank clears, so each spill starts from zero. A synchronous word-addressed register port lets software read and write any counter. Read data is registered.

Top module: `spill_scaler_bank`

## Requirements
- R1: After reset every counter reads zero, and the read data output is zero.
- R2: The spill input is synchronised through two flops. A trigger increments counters only while the synchronised spill is high. Triggers that arrive with spill low, or after spill has fallen and the synchroniser has settled, change no counter.
- R3: The third clock edge after spill is first sampled high clears every counter. This clear takes priority over a register write and over an increment in the same cycle.
- R4: The "all" counter of a quantity increments on every gated trigger. The "read-out" counter increments only when the accepted flag is 1 in the same cycle.
- R5: The register map uses byte offsets. The read-out trigger total is at 0x80 and the all-trigger total is at 0x84. For lookup state n (1 to 15), the read-out counter is at 0x88 + 8*(n-1) and the all counter is at 0x8C + 8*(n-1).
- R6: A trigger with lookup state 0 increments the two trigger totals and no per-state counter.
- R7: A register write loads the addressed counter. A write that coincides with an increment of that counter wins.
- R8: Counters wrap from 0xFFFFFFFF to 0 and do not saturate.
- R9: Any offset below 0x80, and any offset not a multiple of 4, is unused. Reading it returns zero, and writing it changes nothing.
- R10: Read data appears on the clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rstN | input | 1 | Active-low synchronous reset |
| spillIn | input | 1 | Asynchronous spill gate |
| trigStb | input | 1 | One-cycle trigger strobe |
| trigAccepted | input | 1 | Trigger was read out (valid with trigStb) |
| lookupState | input | 4 | Lookup state code of the trigger |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | CNT_W | Write data |
| regRdData | output | CNT_W | Registered read data |

## Verification
The hardest case to reach is the collision on the spill-clear edge. A software write and an accepted trigger must land on exactly the clock edge where the synchronised spill edge clears the bank. The stimulus raises spill at a falling clock edge and counts two rising edges through the synchroniser. It then drives the write and the trigger together, so that all three events meet on the third edge. A similar exact-cycle setup puts a write on top of an increment, and loads counters with 0xFFFFFFFF to force the wrap.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int STATE_BITS = 4;
  localparam int NUM_CNT    = 2 * (2 ** STATE_BITS);

  typedef struct packed {
    logic                  clearAll;
    logic                  incAll;
    logic                  incRo;
    logic [STATE_BITS-1:0] state;
  } tssStrobe_t;
endpackage

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
  import tss_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  spillIn,
  input  logic                  trigStb,
  input  logic                  trigAccepted,
  input  logic [STATE_BITS-1:0] lookupState,
  output tssStrobe_t            strobes
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   spillPrev;
  logic                   spillGate;

  assign spillGate = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ     <= '0;
      spillPrev <= 1'b0;
    end else begin
      syncQ     <= {syncQ[SYNC_STAGES-2:0], spillIn};
      spillPrev <= spillGate;
    end
  end

  always_comb begin
    strobes.clearAll = spillGate & ~spillPrev;
    strobes.incAll   = spillGate & trigStb;
    strobes.incRo    = spillGate & trigStb & trigAccepted;
    strobes.state    = lookupState;
  end
endmodule

// File: rtl/scaler_counters.sv
module scaler_counters
  import tss_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  tssStrobe_t        strobes,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(NUM_CNT);

  logic [WORD_W-1:0] wordAddr;
  logic [WORD_W:0]   wordExt;
  logic              winHit;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cntVal [NUM_CNT];
  logic [CNT_W-1:0]  rdQ;

  assign wordAddr = regAddr[ADDR_W-1:2];
  assign wordExt  = {1'b0, wordAddr};
  assign winHit   = (regAddr[1:0] == 2'b00)
                  && (wordExt >= (WORD_W+1)'(NUM_CNT))
                  && (wordExt <  (WORD_W+1)'(2 * NUM_CNT));
  assign idx      = IDX_W'(wordExt - (WORD_W+1)'(NUM_CNT));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int  ST     = i / 2;
    localparam bit  IS_ALL = (i % 2) == 1;
    logic [CNT_W-1:0] cq;
    logic incHit;
    logic wrHit;

    always_comb begin
      incHit = (IS_ALL ? strobes.incAll : strobes.incRo)
             && ((ST == 0) || (strobes.state == STATE_BITS'(ST)));
      wrHit  = regWrEn && winHit && (idx == IDX_W'(i));
    end

    always_ff @(posedge clk) begin
      if (!rstN)                cq <= '0;
      else if (strobes.clearAll) cq <= '0;
      else if (wrHit)           cq <= regWrData;
      else if (incHit)          cq <= cq + CNT_W'(1);
    end

    assign cntVal[i] = cq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdQ <= '0;
    else       rdQ <= winHit ? cntVal[idx] : '0;
  end

  assign regRdData = rdQ;
endmodule

// File: rtl/spill_scaler_bank.sv
module spill_scaler_bank
  import tss_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spillIn,
  input  logic              trigStb,
  input  logic              trigAccepted,
  input  logic [3:0]        lookupState,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData
);
  tssStrobe_t strobes;

  scaler_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .spillIn(spillIn), .trigStb(trigStb),
    .trigAccepted(trigAccepted), .lookupState(lookupState), .strobes(strobes)
  );

  scaler_counters #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uCnt (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );
endmodule

// File: rtl/spill_scaler_bank_chk.sv
module spill_scaler_bank_chk
  import tss_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              spillIn,
  input logic              trigStb,
  input logic              trigAccepted,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn,
  input logic [CNT_W-1:0]  regWrData,
  input logic [CNT_W-1:0]  regRdData,
  input tssStrobe_t        strobes
);
  logic inWin;
  assign inWin = (regAddr[1:0] == 2'b00) && (regAddr >= ADDR_W'(NUM_CNT * 4));

  // R9: unused offsets read back zero
  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !inWin |=> (regRdData == '0));

  // R3: after the spill-edge clear every counter reads zero
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> ##1 (regRdData == '0));

  // R7: a write not overridden by a clear is read back
  p_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && inWin && !strobes.clearAll) ##1 $stable(regAddr)
      |=> (regRdData == $past(regWrData, 2)));

  // R2: no increment unless spill was high two samples back (default two-stage sync)
  p_gate_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(spillIn, 2) |-> !strobes.incAll);

  // R4: read-out increments need an accepted trigger
  p_ro_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.incRo |-> (trigStb && trigAccepted));
endmodule

bind spill_scaler_bank spill_scaler_bank_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) uChk (.*);

// File: tb/spill_scaler_bank_test.sv
module spill_scaler_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spillIn = 1'b0;
  logic        trigStb = 1'b0;
  logic        trigAccepted = 1'b0;
  logic [3:0]  lookupState = '0;
  logic [7:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] expCnt [32];

  always #5 clk = ~clk;

  spill_scaler_bank uut (
    .clk(clk), .rstN(rstN), .spillIn(spillIn), .trigStb(trigStb),
    .trigAccepted(trigAccepted), .lookupState(lookupState), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk) regAddr = a;
    @(negedge clk) v = regRdData;
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk) begin regAddr = a; regWrEn = 1'b1; regWrData = d; end
    @(negedge clk) regWrEn = 1'b0;
  endtask

  task automatic fireTrig(input logic [3:0] st, input logic acc);
    @(negedge clk) begin trigStb = 1'b1; trigAccepted = acc; lookupState = st; end
    @(negedge clk) trigStb = 1'b0;
  endtask

  function automatic logic [7:0] offs(input int i);
    return 8'(8'h80 + 4 * i);
  endfunction

  task automatic modelTrig(input int st, input logic acc);
    expCnt[1]++;
    if (acc) expCnt[0]++;
    if (st != 0) begin
      expCnt[2*st+1]++;
      if (acc) expCnt[2*st]++;
    end
  endtask

  task automatic checkAll(input string req);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      readReg(offs(i), v);
      check(req, v, expCnt[i]);
    end
  endtask

  task automatic startSpill();
    @(negedge clk) spillIn = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 32; i++) expCnt[i] = '0;
  endtask

  task automatic testReset();
    for (int i = 0; i < 32; i++) expCnt[i] = '0;
    check("R1 rdData", regRdData, 32'h0);
    checkAll("R1");
  endtask

  task automatic testNoSpill();
    logic [31:0] v;
    writeReg(8'h84, 32'd5);
    fireTrig(4'd3, 1'b1);
    fireTrig(4'd0, 1'b0);
    readReg(8'h84, v);
    check("R2 no spill", v, 32'd5);
    readReg(8'h80, v);
    check("R2 no spill ro", v, 32'd0);
  endtask

  task automatic testCounting();
    logic [31:0] v;
    startSpill();
    readReg(8'h84, v);
    check("R3 cleared at spill start", v, 32'd0);
    for (int k = 0; k < 40; k++) begin
      int st = (k * 7) % 16;
      logic acc = ((k % 3) != 0);
      fireTrig(4'(st), acc);
      modelTrig(st, acc);
    end
    fireTrig(4'd15, 1'b1); modelTrig(15, 1'b1);
    fireTrig(4'd0, 1'b1);  modelTrig(0, 1'b1);
    checkAll("R4 R5 R6 counts");
  endtask

  task automatic testWritePriority();
    logic [31:0] v;
    @(negedge clk) begin
      regAddr = 8'h8C; regWrEn = 1'b1; regWrData = 32'h1234_5678;
      trigStb = 1'b1; trigAccepted = 1'b1; lookupState = 4'd1;
    end
    @(negedge clk) begin regWrEn = 1'b0; trigStb = 1'b0; end
    check("R10 latency", regRdData, expCnt[3]);
    modelTrig(1, 1'b1);
    expCnt[3] = 32'h1234_5678;
    readReg(8'h8C, v);
    check("R7 write wins", v, 32'h1234_5678);
    readReg(8'h88, v);
    check("R7 neighbour incremented", v, expCnt[2]);
  endtask

  task automatic testWrap();
    logic [31:0] v;
    writeReg(8'h84, 32'hFFFF_FFFF);
    writeReg(8'hFC, 32'hFFFF_FFFE);
    fireTrig(4'd15, 1'b0);
    readReg(8'h84, v);
    check("R8 wrap", v, 32'h0);
    readReg(8'hFC, v);
    check("R8 top", v, 32'hFFFF_FFFF);
    expCnt[1] = 32'h0;
    expCnt[31] = 32'hFFFF_FFFF;
  endtask

  task automatic testUnused();
    logic [31:0] v;
    writeReg(8'h10, 32'hDEAD_BEEF);
    readReg(8'h10, v);
    check("R9 low offset", v, 32'h0);
    writeReg(8'h81, 32'hCAFE_F00D);
    readReg(8'h81, v);
    check("R9 misaligned", v, 32'h0);
    readReg(8'h40, v);
    check("R9 read", v, 32'h0);
    checkAll("R9 bank untouched");
  endtask

  task automatic testSpillOff();
    @(negedge clk) spillIn = 1'b0;
    repeat (3) @(negedge clk);
    fireTrig(4'd2, 1'b1);
    fireTrig(4'd0, 1'b0);
    checkAll("R2 after spill end");
  endtask

  task automatic testClearCollision();
    logic [31:0] v;
    @(negedge clk) spillIn = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) begin
      regAddr = 8'h90; regWrEn = 1'b1; regWrData = 32'h0000_00AA;
      trigStb = 1'b1; trigAccepted = 1'b1; lookupState = 4'd2;
    end
    @(negedge clk) begin regWrEn = 1'b0; trigStb = 1'b0; end
    for (int i = 0; i < 32; i++) expCnt[i] = '0;
    readReg(8'h90, v);
    check("R3 clear beats write", v, 32'h0);
    checkAll("R3 clear beats increment");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNoSpill();
    testCounting();
    testWritePriority();
    testWrap();
    testUnused();
    testSpillOff();
    testClearCollision();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule